// File: doc/BRIEF.md
# Presence-Detect Image Checker and Decoder

This block walks the low quarter of a 256-byte module-description image held in a byte memory that a separate two-wire bus master has already filled. It issues one read per cycle on a simple synchronous port: address and enable out, data back on the following cycle. While the reads stream in, it adds up a modulo-256 running sum. It also keeps the bytes that describe the module's geometry and timing.

When the stored check byte arrives, the block compares it with the running sum and checks the memory type code and the address-bit counts. It then emits a one-cycle done pulse. The decoded fields are committed to the output registers only if every check passes. Otherwise the error flag rises and all decoded outputs stay at zero. A memory controller starts the walk with a single start pulse and reads the fields after done.

Top module: `spd_decoder`

## Requirements
- R1: A start pulse seen while the block is idle issues reads of addresses 0 to 63 in increasing order, one per cycle, with rd_en high for exactly those 64 cycles. rd_addr never exceeds 63. A start seen while busy has no effect on the sequence.
- R2: Each read's data is consumed on the cycle after its address is issued. busy is high from the cycle after start until the last byte is consumed. done is high for exactly one cycle, beginning at the 66th rising edge when the edge that samples start is counted as the first.
- R3: Byte 63 must equal the low 8 bits of the sum of bytes 0 to 62. Byte 63 is not part of that sum. On a mismatch err is 1 after done.
- R4: When byte 2 (memory type) is not 0x04, err is 1 after done.
- R5: When byte 3 (row address bits) or byte 4 (column address bits) lies outside 8 to 15 inclusive, err is 1 after done.
- R6: All decoded outputs are cleared to zero when a run starts and remain zero during the run. They also remain zero after a run that ends with err set. err is cleared by start and otherwise holds its value while idle.
- R7: On a clean run, row_bits = byte3[3:0], col_bits = byte4[3:0], rank_count = byte5, and data_width = {byte7, byte6}. ecc_module is 1 exactly when data_width is 72.
- R8: On a clean run, refresh_fast is 1 when the low 7 bits of byte 12 equal 2 (7.8 us interval, e.g. 0x82). It is 0 otherwise (e.g. 0x80, 15.6 us).
- R9: On a clean run, burst_mask = byte16 and cas_mask = byte18, passed through as bitmasks.
- R10: On a clean run, tck_tenths = 10*byte9[7:4] + byte9[3:0] (0x75 gives 75, meaning 7.5 ns). trp_ns, trcd_ns and tras_ns equal bytes 27, 29 and 30.
- R11: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk of the image (ignored while busy) |
| rd_en | output | 1 | Read request to the byte memory |
| rd_addr | output | ADDR_W | Read address |
| rd_data | input | 8 | Read data, valid the cycle after the request |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Checksum, type or geometry failure of the last walk |
| row_bits | output | 4 | Row address bit count |
| col_bits | output | 4 | Column address bit count |
| rank_count | output | 8 | Number of module ranks |
| data_width | output | 16 | Module data width |
| ecc_module | output | 1 | Width is 72 (error-correcting module) |
| refresh_fast | output | 1 | 7.8 us refresh interval |
| burst_mask | output | 8 | Supported burst lengths |
| cas_mask | output | 8 | Supported CAS latencies |
| tck_tenths | output | 8 | Minimum cycle time in tenths of a ns |
| trp_ns | output | 8 | Row precharge time, ns |
| trcd_ns | output | 8 | Row-to-column delay, ns |
| tras_ns | output | 8 | Row active time, ns |

## Verification
The bench targets images whose checksum wraps past 255. A design that kept a wider sum, or that added byte 63 to itself, would flag a good image as bad. It also feeds images that are correct except for one flaw: a wrong check byte, a non-SDRAM type, a row count of 16 or a column count of 7. A design that let any of these through would show nonzero fields with err low. A clean run followed by a failing one shows whether stale fields survive. A start pulse in the middle of a walk shows whether the read sequence restarts or the done pulse moves.

// File: rtl/spd_decoder.sv
module spd_decoder #(
  parameter int ADDR_W    = 8,
  parameter int NUM_BYTES = 64,
  parameter logic [7:0] TYPE_CODE = 8'h04,
  parameter int MIN_AB    = 8,
  parameter int MAX_AB    = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [3:0]        row_bits,
  output logic [3:0]        col_bits,
  output logic [7:0]        rank_count,
  output logic [15:0]       data_width,
  output logic              ecc_module,
  output logic              refresh_fast,
  output logic [7:0]        burst_mask,
  output logic [7:0]        cas_mask,
  output logic [7:0]        tck_tenths,
  output logic [7:0]        trp_ns,
  output logic [7:0]        trcd_ns,
  output logic [7:0]        tras_ns
);
  localparam logic [ADDR_W-1:0] A_LAST  = ADDR_W'(NUM_BYTES - 1);
  localparam logic [ADDR_W-1:0] A_TYPE  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_ROW   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_COL   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_RANK  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_WLO   = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_WHI   = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_TCK   = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] A_REF   = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] A_BL    = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] A_CL    = ADDR_W'(18);
  localparam logic [ADDR_W-1:0] A_TRP   = ADDR_W'(27);
  localparam logic [ADDR_W-1:0] A_TRCD  = ADDR_W'(29);
  localparam logic [ADDR_W-1:0] A_TRAS  = ADDR_W'(30);
  localparam logic [15:0]       ECC_W   = 16'd72;

  logic              issuing, vld;
  logic [ADDR_W-1:0] addr_q, vaddr;
  logic [7:0]        sum;
  logic              type_ok, row_ok, col_ok;
  logic [3:0]        s_row, s_col;
  logic [7:0]        s_rank, s_wlo, s_whi, s_ref, s_bl, s_cl, s_tck;
  logic [7:0]        s_trp, s_trcd, s_tras;

  assign busy    = issuing | vld;
  assign rd_en   = issuing;
  assign rd_addr = addr_q;

  wire go        = start & ~busy;
  wire in_range  = (rd_data >= 8'(MIN_AB)) && (rd_data <= 8'(MAX_AB));
  wire last_in   = vld && (vaddr == A_LAST);
  wire bad       = (rd_data != sum) | ~type_ok | ~row_ok | ~col_ok;
  wire [7:0] tck_dec = ({4'b0, rd_data[7:4]} * 8'd10) + {4'b0, rd_data[3:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issuing <= 1'b0;
      vld     <= 1'b0;
      addr_q  <= '0;
      vaddr   <= '0;
      sum     <= '0;
    end else begin
      vld   <= issuing;
      vaddr <= addr_q;
      if (go) begin
        issuing <= 1'b1;
        addr_q  <= '0;
        sum     <= '0;
      end else if (issuing) begin
        if (addr_q == A_LAST) issuing <= 1'b0;
        else                  addr_q  <= addr_q + 1'b1;
      end
      if (vld && vaddr != A_LAST) sum <= sum + rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_ok <= 1'b0; row_ok <= 1'b0; col_ok <= 1'b0;
      s_row <= '0; s_col <= '0; s_rank <= '0; s_wlo <= '0; s_whi <= '0;
      s_ref <= '0; s_bl <= '0; s_cl <= '0; s_tck <= '0;
      s_trp <= '0; s_trcd <= '0; s_tras <= '0;
    end else if (vld) begin
      case (vaddr)
        A_TYPE: type_ok <= (rd_data == TYPE_CODE);
        A_ROW:  begin row_ok <= in_range; s_row <= rd_data[3:0]; end
        A_COL:  begin col_ok <= in_range; s_col <= rd_data[3:0]; end
        A_RANK: s_rank <= rd_data;
        A_WLO:  s_wlo  <= rd_data;
        A_WHI:  s_whi  <= rd_data;
        A_TCK:  s_tck  <= tck_dec;
        A_REF:  s_ref  <= rd_data;
        A_BL:   s_bl   <= rd_data;
        A_CL:   s_cl   <= rd_data;
        A_TRP:  s_trp  <= rd_data;
        A_TRCD: s_trcd <= rd_data;
        A_TRAS: s_tras <= rd_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0; err <= 1'b0;
      row_bits <= '0; col_bits <= '0; rank_count <= '0; data_width <= '0;
      ecc_module <= 1'b0; refresh_fast <= 1'b0; burst_mask <= '0; cas_mask <= '0;
      tck_tenths <= '0; trp_ns <= '0; trcd_ns <= '0; tras_ns <= '0;
    end else begin
      done <= last_in;
      if (go) begin
        err <= 1'b0;
        row_bits <= '0; col_bits <= '0; rank_count <= '0; data_width <= '0;
        ecc_module <= 1'b0; refresh_fast <= 1'b0; burst_mask <= '0; cas_mask <= '0;
        tck_tenths <= '0; trp_ns <= '0; trcd_ns <= '0; tras_ns <= '0;
      end else if (last_in) begin
        err <= bad;
        if (!bad) begin
          row_bits     <= s_row;
          col_bits     <= s_col;
          rank_count   <= s_rank;
          data_width   <= {s_whi, s_wlo};
          ecc_module   <= ({s_whi, s_wlo} == ECC_W);
          refresh_fast <= (s_ref[6:0] == 7'd2);
          burst_mask   <= s_bl;
          cas_mask     <= s_cl;
          tck_tenths   <= s_tck;
          trp_ns       <= s_trp;
          trcd_ns      <= s_trcd;
          tras_ns      <= s_tras;
        end
      end
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + 1'b1)); // R1
  AST_ADDR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_addr <= A_LAST)); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(rd_en, 2) && $past(rd_addr, 2) == A_LAST && !busy)); // R2
  AST_ERR_ZERO_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (row_bits == 0 && col_bits == 0 && rank_count == 0 && data_width == 0
             && tck_tenths == 0 && tras_ns == 0)); // R6
  AST_ERR_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(err)); // R6
endmodule

// File: tb/spd_decoder_tb.sv
`timescale 1ns/1ps
module spd_decoder_tb;
  logic clk = 0, rst_n = 0, start = 0;
  logic rd_en, busy, done, err, ecc_module, refresh_fast;
  logic [7:0] rd_addr, rd_data;
  logic [3:0] row_bits, col_bits;
  logic [7:0] rank_count, burst_mask, cas_mask, tck_tenths, trp_ns, trcd_ns, tras_ns;
  logic [15:0] data_width;
  logic [7:0] mem [256];
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  spd_decoder u_dut (.clk, .rst_n, .start, .rd_en, .rd_addr, .rd_data, .busy, .done, .err,
    .row_bits, .col_bits, .rank_count, .data_width, .ecc_module, .refresh_fast,
    .burst_mask, .cas_mask, .tck_tenths, .trp_ns, .trcd_ns, .tras_ns);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic build(input int rows, input int cols, input int ranks, input int refr);
    for (int i = 0; i < 256; i++) mem[i] = 8'hEE;
    for (int i = 0; i < 63; i++) mem[i] = 8'((i * 37 + 11) & 8'hFF);
    mem[0] = 8'h80; mem[1] = 8'h08; mem[2] = 8'h04; mem[3] = 8'(rows); mem[4] = 8'(cols);
    mem[5] = 8'(ranks); mem[6] = 8'h48; mem[7] = 8'h00; mem[9] = 8'h75; mem[12] = 8'(refr);
    mem[16] = 8'h8F; mem[18] = 8'h06; mem[27] = 8'h14; mem[29] = 8'h14; mem[30] = 8'h2D;
  endtask

  task automatic fix_sum();
    int s = 0;
    for (int i = 0; i < 63; i++) s += mem[i];
    mem[63] = 8'(s % 256);
  endtask

  function automatic bit exp_bad();
    int s = 0;
    for (int i = 0; i < 63; i++) s += mem[i];
    return (8'(s % 256) != mem[63]) || (mem[2] != 8'h04) ||
           (mem[3] < 8) || (mem[3] > 15) || (mem[4] < 8) || (mem[4] > 15);
  endfunction

  task automatic check_fields(input bit bad, input string tag);
    int w = {mem[7], mem[6]};
    int t = (mem[9] >> 4) * 10 + (mem[9] & 15);
    chk(err == bad, {"R3 R4 R5 err ", tag}, err, bad);
    chk(row_bits == (bad ? 0 : mem[3][3:0]), {"R7 row ", tag}, row_bits, bad ? 0 : mem[3][3:0]);
    chk(col_bits == (bad ? 0 : mem[4][3:0]), {"R7 col ", tag}, col_bits, bad ? 0 : mem[4][3:0]);
    chk(rank_count == (bad ? 0 : mem[5]), {"R7 rank ", tag}, rank_count, bad ? 0 : mem[5]);
    chk(data_width == (bad ? 0 : w), {"R7 width ", tag}, data_width, bad ? 0 : w);
    chk(ecc_module == (!bad && w == 72), {"R7 ecc ", tag}, ecc_module, !bad && w == 72);
    chk(refresh_fast == (!bad && mem[12][6:0] == 2), {"R8 refresh ", tag}, refresh_fast,
        !bad && mem[12][6:0] == 2);
    chk(burst_mask == (bad ? 0 : mem[16]), {"R9 burst ", tag}, burst_mask, bad ? 0 : mem[16]);
    chk(cas_mask == (bad ? 0 : mem[18]), {"R9 cas ", tag}, cas_mask, bad ? 0 : mem[18]);
    chk(tck_tenths == (bad ? 0 : t), {"R10 tck ", tag}, tck_tenths, bad ? 0 : t);
    chk(trp_ns == (bad ? 0 : mem[27]), {"R10 trp ", tag}, trp_ns, bad ? 0 : mem[27]);
    chk(trcd_ns == (bad ? 0 : mem[29]), {"R10 trcd ", tag}, trcd_ns, bad ? 0 : mem[29]);
    chk(tras_ns == (bad ? 0 : mem[30]), {"R10 tras ", tag}, tras_ns, bad ? 0 : mem[30]);
  endtask

  task automatic run(input string tag, input bit poke_start);
    bit bad = exp_bad();
    @(negedge clk) start = 1;
    for (int k = 1; k <= 67; k++) begin
      @(negedge clk);
      if (k == 1) start = 0;
      if (poke_start && k == 10) start = 1;
      if (poke_start && k == 11) start = 0;
      chk(rd_en == (k <= 64), {"R1 rd_en ", tag}, rd_en, k <= 64);
      if (k <= 64) chk(rd_addr == 8'(k - 1), {"R1 rd_addr ", tag}, rd_addr, k - 1);
      chk(busy == (k <= 65), {"R2 busy ", tag}, busy, k <= 65);
      chk(done == (k == 66), {"R2 done ", tag}, done, k == 66);
      if (k == 30) chk(row_bits == 0 && tras_ns == 0 && err == 0, {"R6 cleared ", tag},
                       {row_bits, tras_ns}, 0);
      if (k >= 66) check_fields(bad, tag);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    build(13, 11, 1, 8'h82); fix_sum();
    repeat (3) @(negedge clk);
    chk(!rd_en && !busy && !done && !err && row_bits == 0 && data_width == 0 && tck_tenths == 0,
        "R11 reset", {rd_en, busy, done, err}, 0);
    rst_n = 1;
    @(negedge clk);
    run("clean A", 0);
    build(12, 10, 2, 8'h80); mem[6] = 8'h40; fix_sum();
    run("clean B with start while busy", 1);
    build(13, 12, 2, 8'h82); fix_sum(); mem[63] = mem[63] + 8'd1;
    run("bad checksum R3", 0);
    repeat (5) @(negedge clk);
    chk(err == 1, "R6 err held idle", err, 1);
    build(13, 11, 1, 8'h82); mem[2] = 8'h02; fix_sum();
    run("bad type R4", 0);
    build(16, 11, 1, 8'h82); fix_sum();
    run("row 16 R5", 0);
    build(15, 7, 1, 8'h82); fix_sum();
    run("col 7 R5", 0);
    build(8, 15, 1, 8'h80); fix_sum();
    run("range edges R5", 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule